// File: doc/BRIEF.md
# Interrupt Request Front End with Mask Control

This block sits in front of a small 8-bit CPU core and decides which interrupt request, if any, the core should take at each instruction boundary. It watches five request lines: one non-maskable line, three fixed-vector restart lines at levels 7.5, 6.5 and 5.5, and one external request that carries no fixed vector. It keeps the global enable flip-flop and three per-line mask bits. It accepts a mask-write byte from the core and returns a status byte.

Each line has its own trigger rule. The non-maskable line has to rise and then stay high. The 7.5 line sets a pending flag on a rising edge. The 6.5 and 5.5 lines are seen only as levels. The external request depends only on the enable flip-flop. The block also holds the serial output bit written through the mask byte, and it copies the serial input pin into the status byte.

When the core pulses `boundary_i`, the block registers the winning request together with its source code and its 16-bit restart address. The request stays presented until the core pulses `ack_i`. The acknowledge consumes the request and has the side effects listed below.

Top module: `irq_mask_unit`

## Requirements
- R1: Reset leaves the enable flip-flop cleared, all three mask bits set, nothing pending, no request presented and the serial output low. With all inputs low, the status byte is therefore 0x07.
- R2: A mask write with bit 3 set loads bits 2:0 into the masks. Bit 0 masks 5.5, bit 1 masks 6.5 and bit 2 masks 7.5, and a 1 blocks the line. A mask write with bit 3 clear leaves all three masks unchanged.
- R3: In a mask write, bit 4 clears the 7.5 pending flag and bit 5 has no effect. When bit 6 is set, bit 7 is copied to `serial_o`. When bit 6 is clear, `serial_o` keeps its value.
- R4: The status byte carries the masks for 5.5, 6.5 and 7.5 in bits 0 to 2, the enable flip-flop in bit 3, the 5.5 line in bit 4, the 6.5 line in bit 5, the 7.5 pending flag in bit 6 and `serial_i` in bit 7.
- R5: After a two-flop synchronizer, a rising edge on the 7.5 line sets its pending flag, and the line may drop again at once. While the line stays high, no further edge is seen.
- R6: The 6.5 and 5.5 lines are candidates only if they are high in the boundary cycle, unmasked, and the enable flip-flop is set.
- R7: The non-maskable line, after synchronization, is a candidate only after a low-to-high transition that is still held high. It ignores the enable flip-flop and all masks, and its vector is 0x0024. After it is acknowledged, it is not taken again until it goes low and then high again.
- R8: A pulse on `en_set_i` makes the enable effective only after the next boundary, so the request is evaluated no earlier than the boundary after that. A pulse on `en_clr_i` clears the enable at once.
- R9: Acknowledging any maskable request clears the enable flip-flop. The external request has no mask bit. It is presented with `req_vectored_o` low and a vector of 0.
- R10: Priority runs from the non-maskable line, through 7.5, 6.5 and 5.5, to the external request. The source codes are 0, 1, 2, 3 and 4 in that order, and the vectors are 0x0024, 0x003C, 0x0034, 0x002C and 0.
- R11: Acknowledging a 7.5 request clears its pending flag.
- R12: `boundary_i` registers the winner, or no request, for the next cycle. The request stays unchanged until `ack_i`, and `ack_i` has no effect when nothing is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request line |
| edge_req_i | input | 1 | Edge-latched restart line, level 7.5 |
| lvl_hi_i | input | 1 | Level restart line, level 6.5 |
| lvl_lo_i | input | 1 | Level restart line, level 5.5 |
| ext_req_i | input | 1 | External request without a fixed vector |
| serial_i | input | 1 | Serial input pin, reported in the status byte |
| boundary_i | input | 1 | Instruction boundary pulse from the core |
| ack_i | input | 1 | Core accepts the presented request |
| en_set_i | input | 1 | Enable-interrupts command |
| en_clr_i | input | 1 | Disable-interrupts command |
| mask_wr_i | input | 1 | Mask-write strobe |
| mask_data_i | input | 8 | Mask-write byte |
| status_o | output | 8 | Status byte |
| serial_o | output | 1 | Serial output bit |
| req_valid_o | output | 1 | A request is presented |
| req_src_o | output | 3 | Source code of the presented request |
| req_vector_o | output | 16 | Restart address of the presented request |
| req_vectored_o | output | 1 | The presented request has a fixed vector |

## Verification
The bench goes after the edge-and-level rule of the non-maskable line. A pulse too short to reach the held state must not be taken, and a line still held high after acknowledge must not be taken twice; a design that treated the line as a plain level would present it again at once. It probes the one-instruction delay of the enable command, which a design without the delay would break by presenting the request one boundary early. It also covers the 7.5 line in three ways: its pending flag must survive the line dropping, it must not re-arm while the line is held high, and it must clear through the mask byte. Finally, the bench checks the priority chain one step at a time by masking or dropping each winner. A wrong order or vector shows up as a mismatched source code or address.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int VEC_W = 16;
  localparam int NSRC  = 5;

  typedef enum logic [2:0] {
    SRC_NMI = 3'd0,
    SRC_E75 = 3'd1,
    SRC_L65 = 3'd2,
    SRC_L55 = 3'd3,
    SRC_EXT = 3'd4
  } irq_src_e;

  // restart number times eight; half levels expressed as twice-number times four
  function automatic logic [VEC_W-1:0] vec_of(irq_src_e s);
    case (s)
      SRC_NMI: vec_of = VEC_W'(9  * 4);
      SRC_E75: vec_of = VEC_W'(15 * 4);
      SRC_L65: vec_of = VEC_W'(13 * 4);
      SRC_L55: vec_of = VEC_W'(11 * 4);
      default: vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_mask_pkg::*;
(
  input  logic [NSRC-1:0] cand_i,
  output logic            any_o,
  output irq_src_e        win_o
);
  // lowest index wins
  always_comb begin
    win_o = SRC_NMI;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (cand_i[i]) win_o = irq_src_e'(i[2:0]);
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             edge_req_i,
  input  logic             lvl_hi_i,
  input  logic             lvl_lo_i,
  input  logic             ext_req_i,
  input  logic             serial_i,
  input  logic             boundary_i,
  input  logic             ack_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_data_i,
  output logic [7:0]       status_o,
  output logic             serial_o,
  output logic             req_valid_o,
  output logic [2:0]       req_src_o,
  output logic [VEC_W-1:0] req_vector_o,
  output logic             req_vectored_o
);
  logic [1:0]      sync_s;
  logic            nmi_s, e75_s, nmi_d, e75_d;
  logic            nmi_rise, e75_rise;
  logic            trap_arm_q, pend75_q, ie_q, ie_arm_q, ser_q, valid_q;
  logic [2:0]      mask_q;
  irq_src_e        src_q, win;
  logic            any;
  logic [NSRC-1:0] cand;
  logic            take, clr75;
  logic            unused_bit5;

  assign unused_bit5 = mask_data_i[5];

  irq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({edge_req_i, nmi_i}),
    .q_o   (sync_s)
  );
  assign nmi_s = sync_s[0];
  assign e75_s = sync_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d <= 1'b0;
      e75_d <= 1'b0;
    end else begin
      nmi_d <= nmi_s;
      e75_d <= e75_s;
    end
  end
  assign nmi_rise = nmi_s & ~nmi_d;
  assign e75_rise = e75_s & ~e75_d;

  assign take  = ack_i & valid_q;
  assign clr75 = (mask_wr_i & mask_data_i[4]) | (take & (src_q == SRC_E75));

  assign cand[SRC_NMI] = trap_arm_q & nmi_s;
  assign cand[SRC_E75] = pend75_q & ~mask_q[2] & ie_q;
  assign cand[SRC_L65] = lvl_hi_i & ~mask_q[1] & ie_q;
  assign cand[SRC_L55] = lvl_lo_i & ~mask_q[0] & ie_q;
  assign cand[SRC_EXT] = ext_req_i & ie_q;

  irq_prio u_prio (
    .cand_i(cand),
    .any_o (any),
    .win_o (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_arm_q <= 1'b0;
      pend75_q   <= 1'b0;
      mask_q     <= 3'b111;
      ser_q      <= 1'b0;
      ie_q       <= 1'b0;
      ie_arm_q   <= 1'b0;
      valid_q    <= 1'b0;
      src_q      <= SRC_NMI;
    end else begin
      if (nmi_rise) trap_arm_q <= 1'b1;
      else if (!nmi_s || (take && src_q == SRC_NMI)) trap_arm_q <= 1'b0;

      if (e75_rise) pend75_q <= 1'b1;
      else if (clr75) pend75_q <= 1'b0;

      if (mask_wr_i && mask_data_i[3]) mask_q <= mask_data_i[2:0];
      if (mask_wr_i && mask_data_i[6]) ser_q <= mask_data_i[7];

      // enable becomes effective one boundary after the command
      if (en_clr_i || (take && src_q != SRC_NMI)) begin
        ie_q     <= 1'b0;
        ie_arm_q <= 1'b0;
      end else if (en_set_i) begin
        ie_arm_q <= 1'b1;
      end else if (boundary_i && ie_arm_q) begin
        ie_q     <= 1'b1;
        ie_arm_q <= 1'b0;
      end

      if (take) valid_q <= 1'b0;
      else if (boundary_i) begin
        valid_q <= any;
        src_q   <= win;
      end
    end
  end

  assign status_o       = {serial_i, pend75_q, lvl_hi_i, lvl_lo_i, ie_q, mask_q};
  assign serial_o       = ser_q;
  assign req_valid_o    = valid_q;
  assign req_src_o      = src_q;
  assign req_vector_o   = valid_q ? vec_of(src_q) : '0;
  assign req_vectored_o = valid_q & (src_q != SRC_EXT);

  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && !mask_data_i[3]) |=> $stable(mask_q));
  assert_trap_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_src_o == SRC_NMI) |-> (req_vector_o == 16'h0024));
  assert_ie_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_valid_o) && req_src_o != SRC_NMI) |-> $past(ie_q));
  assert_ie_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && src_q != SRC_NMI) |=> !ie_q);
  assert_pend_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && src_q == SRC_E75 && !e75_rise) |=> !pend75_q);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !ack_i && !boundary_i) |=> (req_valid_o && $stable(req_src_o)));
endmodule

// File: tb/test_irq_mask_unit.sv
module test_irq_mask_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, edge_req = 0, lvl_hi = 0, lvl_lo = 0, ext_req = 0, sin = 0;
  logic boundary = 0, ack = 0, en_set = 0, en_clr = 0, mask_wr = 0;
  logic [7:0] mask_data = 0;
  logic [7:0] status;
  logic sout, rvalid, rvectored;
  logic [2:0] rsrc;
  logic [15:0] rvec;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_mask_unit i_irq_mask_unit (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .edge_req_i(edge_req),
    .lvl_hi_i(lvl_hi), .lvl_lo_i(lvl_lo), .ext_req_i(ext_req), .serial_i(sin),
    .boundary_i(boundary), .ack_i(ack), .en_set_i(en_set), .en_clr_i(en_clr),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data), .status_o(status),
    .serial_o(sout), .req_valid_o(rvalid), .req_src_o(rsrc),
    .req_vector_o(rvec), .req_vectored_o(rvectored)
  );

  // behavioural reference state
  bit n_hist[$], e_hist[$];
  bit m_nprev, m_eprev, m_trap, m_p75, m_ie, m_arm, m_ser, m_val;
  bit [2:0] m_mask;
  int m_src;

  function automatic logic [15:0] exp_vec(int s);
    case (s)
      0: return 16'h0024;
      1: return 16'h003C;
      2: return 16'h0034;
      3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    n_hist = '{0, 0}; e_hist = '{0, 0};
    m_nprev = 0; m_eprev = 0; m_trap = 0; m_p75 = 0; m_ie = 0; m_arm = 0;
    m_ser = 0; m_val = 0; m_mask = 3'b111; m_src = 0;
  endtask

  task automatic model_step();
    bit ns, es, rise, erise, take;
    int win;
    if (!rst_n) begin model_reset(); return; end
    ns = n_hist[1]; es = e_hist[1];
    rise = ns && !m_nprev; erise = es && !m_eprev;
    take = ack && m_val;
    win = -1;
    if (m_trap && ns) win = 0;
    else if (m_p75 && !m_mask[2] && m_ie) win = 1;
    else if (lvl_hi && !m_mask[1] && m_ie) win = 2;
    else if (lvl_lo && !m_mask[0] && m_ie) win = 3;
    else if (ext_req && m_ie) win = 4;
    if (rise) m_trap = 1; else if (!ns || (take && m_src == 0)) m_trap = 0;
    if (erise) m_p75 = 1;
    else if ((mask_wr && mask_data[4]) || (take && m_src == 1)) m_p75 = 0;
    if (mask_wr && mask_data[3]) m_mask = mask_data[2:0];
    if (mask_wr && mask_data[6]) m_ser = mask_data[7];
    if (en_clr || (take && m_src != 0)) begin m_ie = 0; m_arm = 0; end
    else if (en_set) m_arm = 1;
    else if (boundary && m_arm) begin m_ie = 1; m_arm = 0; end
    if (take) m_val = 0;
    else if (boundary) begin m_val = (win >= 0); m_src = (win >= 0) ? win : 0; end
    m_nprev = ns; m_eprev = es;
    n_hist = '{nmi, n_hist[0]}; e_hist = '{edge_req, e_hist[0]};
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R12 valid", 16'(rvalid), 16'(m_val));
    if (m_val) chk("R10 source", 16'(rsrc), 16'(m_src));
    chk("R10 vector", rvec, m_val ? exp_vec(m_src) : 16'h0);
    chk("R9 vectored", 16'(rvectored), 16'(m_val && m_src != 4));
    chk("R4 status", 16'(status), 16'({sin, m_p75, lvl_hi, lvl_lo, m_ie, m_mask}));
    chk("R3 serial", 16'(sout), 16'(m_ser));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_step();
      @(negedge clk); compare();
    end
  endtask

  task automatic wr_mask(logic [7:0] v);
    mask_wr = 1; mask_data = v; tick(); mask_wr = 0; mask_data = 0;
  endtask
  task automatic bnd(); boundary = 1; tick(); boundary = 0; endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic enable_ie(); en_set = 1; tick(); en_set = 0; bnd(); endtask

  initial begin
    model_reset();
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 status", 16'(status), 16'h0007);
    chk("R1 valid", 16'(rvalid), 16'h0);
    chk("R1 serial", 16'(sout), 16'h0);

    // R2 mask writes
    wr_mask(8'h08); chk("R2 load", 16'(status), 16'h0000);
    wr_mask(8'h07); chk("R2 hold", 16'(status), 16'h0000);
    wr_mask(8'h2A); chk("R3 bit5 ignored", 16'(status), 16'h0002);
    wr_mask(8'h08);

    // R3 serial out
    wr_mask(8'hC0); chk("R3 serial set", 16'(sout), 16'h1);
    wr_mask(8'h00); chk("R3 serial keep", 16'(sout), 16'h1);
    wr_mask(8'h40); chk("R3 serial clear", 16'(sout), 16'h0);

    // R4 status layout
    lvl_lo = 1; tick(); chk("R4 bit4", 16'(status), 16'h0010);
    lvl_lo = 0; lvl_hi = 1; sin = 1; tick(); chk("R4 bits5,7", 16'(status), 16'h00A0);
    lvl_hi = 0; sin = 0; tick();

    // R12 ack when idle
    do_ack(); chk("R12 idle ack", 16'(rvalid), 16'h0);

    // R8 enable delay, R9 external request
    ext_req = 1;
    en_set = 1; tick(); en_set = 0;
    bnd(); chk("R8 not yet", 16'(rvalid), 16'h0);
    chk("R8 ie now set", 16'(status[3]), 16'h1);
    bnd(); chk("R9 ext valid", 16'(rvalid), 16'h1);
    chk("R9 ext src", 16'(rsrc), 16'h4);
    chk("R9 ext unvectored", 16'(rvectored), 16'h0);
    tick(2); chk("R12 held", 16'(rvalid), 16'h1);
    do_ack(); chk("R9 ie cleared", 16'(status[3]), 16'h0);
    bnd(); chk("R9 disabled", 16'(rvalid), 16'h0);
    en_set = 1; tick(); en_set = 0; en_clr = 1; tick(); en_clr = 0;
    bnd(); bnd(); chk("R8 clear", 16'(rvalid), 16'h0);
    ext_req = 0; tick();

    // R5 edge latch and R3 bit4 clear
    edge_req = 1; tick(); edge_req = 0; tick(4);
    chk("R5 pending", 16'(status[6]), 16'h1);
    wr_mask(8'h10); chk("R3 bit4 clear", 16'(status[6]), 16'h0);
    edge_req = 1; tick(5);
    chk("R5 latched", 16'(status[6]), 16'h1);
    lvl_hi = 1; lvl_lo = 1; ext_req = 1;
    enable_ie(); bnd();
    chk("R10 e75 wins", 16'(rsrc), 16'h1);
    chk("R10 vec 3C", rvec, 16'h003C);
    do_ack(); tick(3);
    chk("R11 pend cleared", 16'(status[6]), 16'h0);
    chk("R5 no rearm while high", 16'(status[6]), 16'h0);
    edge_req = 0; tick(3);
    edge_req = 1; tick(); edge_req = 0; tick(4);
    chk("R5 re-edge", 16'(status[6]), 16'h1);
    wr_mask(8'h10);

    // R10 priority chain, R6 levels
    enable_ie(); bnd();
    chk("R10 l65", 16'(rsrc), 16'h2); chk("R10 vec 34", rvec, 16'h0034);
    do_ack(); lvl_hi = 0;
    enable_ie(); bnd();
    chk("R10 l55", 16'(rsrc), 16'h3); chk("R10 vec 2C", rvec, 16'h002C);
    do_ack(); wr_mask(8'h09);
    enable_ie(); bnd();
    chk("R6 masked l55", 16'(rsrc), 16'h4);
    do_ack(); ext_req = 0; wr_mask(8'h08);
    enable_ie(); lvl_lo = 0; bnd();
    chk("R6 level dropped", 16'(rvalid), 16'h0);
    lvl_lo = 1; bnd(); chk("R6 level held", 16'(rsrc), 16'h3);
    do_ack(); lvl_lo = 0; tick();

    // R7 trap
    wr_mask(8'h0F);
    nmi = 1; tick(); nmi = 0; tick(5);
    bnd(); chk("R7 short pulse", 16'(rvalid), 16'h0);
    nmi = 1; tick(5);
    bnd(); chk("R7 taken", 16'(rvalid), 16'h1);
    chk("R7 src", 16'(rsrc), 16'h0); chk("R7 vec", rvec, 16'h0024);
    do_ack(); tick(2);
    bnd(); chk("R7 no retake", 16'(rvalid), 16'h0);
    nmi = 0; tick(4); nmi = 1; tick(5);
    bnd(); chk("R7 rearmed", 16'(rvalid), 16'h1);
    do_ack(); nmi = 0; tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule